// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM with 19 address bits and bytes of 8 bits. The requester offers one word at a time with a valid/ready handshake that carries an address, a write flag and write data. The controller then drives the RAM's active-low chip enable, write enable and output enable, the address bus, and a data-out bus with its own enable for the bidirectional pins. A read ends with a one-cycle valid pulse that carries the captured byte.

All analog timing is turned into clock-cycle counts when the block is built. Each count is rounded up from a nanosecond figure and the clock period, so every minimum holds. The controller changes the address only while both strobes are high. A write happens only while chip enable and write enable are low together. Output enable stays high for the whole of a write, so the pad drivers and the RAM never drive the data pins at the same time.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `mem_cs_n`, `mem_wr_n` and `mem_rd_n` are 1, `mem_dq_drive` is 0, `req_ready` is 1 and `rsp_valid` is 0. A reset given in the middle of an operation returns the pins to this state.
- R2: `mem_addr` takes the accepted request's address one clock edge after acceptance. It changes only in a cycle where `mem_cs_n` and `mem_wr_n` are both 1, both before and after the change.
- R3: `req_ready` is 1 only while the controller is idle with all strobes high. A request moves on only on an edge where `req_valid` and `req_ready` are both 1. Request inputs that change while `req_ready` is 0 have no effect on the operation in progress.
- R4: A read drives `mem_cs_n`=0 and `mem_rd_n`=0 with `mem_wr_n`=1 for ACC_CYC = ceil(ACCESS_NS/CLK_NS) cycles. The address is stable for one full cycle before chip enable falls. `mem_dq_in` is sampled at the end of the last access cycle.
- R5: A write holds `mem_cs_n`=0 and `mem_wr_n`=0 together for WP_CYC = ceil(WPULSE_NS/CLK_NS) cycles. `mem_rd_n` stays 1 and `mem_dq_drive` stays 1 throughout, and a write never produces `rsp_valid`.
- R6: `mem_dq_drive` rises only when `mem_rd_n` was 1 in the previous cycle and is 1 now. It stays 1 for HOLD_CYC (at least one) cycles after `mem_wr_n` rises, and is never 1 while `mem_rd_n` is 0.
- R7: After each access, all strobes stay high for REC_CYC (at least one) recovery cycles before `req_ready` returns. Counting clock edges after the accepting edge, `req_ready` is 1 again after ACC_CYC+REC_CYC+1 edges for a read and WP_CYC+HOLD_CYC+REC_CYC+1 edges for a write.
- R8: `rsp_valid` is a one-cycle pulse, high in the cycle after the (ACC_CYC+1)-th edge after acceptance. `rsp_data` then equals the byte most recently written to that address, or 0x00 for an address never written in the bench's RAM model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | 19 | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read byte valid |
| rsp_data | output | 8 | Captured read byte |
| mem_addr | output | 19 | RAM address bus |
| mem_cs_n | output | 1 | RAM chip enable, active low |
| mem_wr_n | output | 1 | RAM write enable, active low |
| mem_rd_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM pins |
| mem_dq_drive | output | 1 | Enable for the pad drivers of the data pins |
| mem_dq_in | input | 8 | Data seen on the RAM pins |

## Verification
The assertions take the requester's inputs as free. They assume only that reset is held for at least two clock edges, so that no history from before a reset taken mid-write can reach the first checked cycle. The bench drives the request inputs on falling edges and holds reset for three edges every time. It deliberately scrambles the request address and data while the controller is busy, to show those inputs are ignored. The RAM model returns a poison byte until the access window has elapsed. It counts every address change under a low strobe, every write overlap without driven data, and every cycle in which both sides drive the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_SETUP    = 3'd1,
        PH_RD_ACC   = 3'd2,
        PH_WR_PULSE = 3'd3,
        PH_WR_HOLD  = 3'd4,
        PH_RECOV    = 3'd5
    } phase_e;

    // Pin-level control bundle, registered so the external strobes cannot glitch.
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic dq_drive;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, dq_drive: 1'b0};

    // Round a nanosecond figure up to whole clock cycles, with a floor.
    function automatic int ns_to_cyc(input int ns, input int clk_ns, input int min_cyc);
        int r;
        r = (ns + clk_ns - 1) / clk_ns;
        if (r < min_cyc) r = min_cyc;
        return r;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Pin levels that belong to each phase.
    function automatic strobe_t strobes_of(input phase_e ph);
        strobe_t s;
        s = STROBE_QUIET;
        case (ph)
            PH_RD_ACC: begin
                s.cs_n = 1'b0;
                s.rd_n = 1'b0;
            end
            PH_WR_PULSE: begin
                s.cs_n     = 1'b0;
                s.wr_n     = 1'b0;
                s.dq_drive = 1'b1;
            end
            PH_WR_HOLD: s.dq_drive = 1'b1;
            default: s = STROBE_QUIET;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ACC_CYC  = 3,
    parameter int WP_CYC   = 3,
    parameter int HOLD_CYC = 1,
    parameter int REC_CYC  = 1,
    parameter int CNT_W    = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    idle,
    output logic    accept,
    output logic    capture,
    output strobe_t pins
);
    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

    phase_e           phase_q, phase_d;
    logic             is_wr_q;
    logic             t_load, t_done;
    logic [CNT_W-1:0] t_val;
    strobe_t          pins_q;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    always_comb begin
        phase_d = phase_q;
        t_load  = 1'b0;
        t_val   = '0;
        capture = 1'b0;
        case (phase_q)
            PH_IDLE: if (req_valid) phase_d = PH_SETUP;
            PH_SETUP: begin
                t_load = 1'b1;
                if (is_wr_q) begin
                    phase_d = PH_WR_PULSE;
                    t_val   = WP_LD;
                end else begin
                    phase_d = PH_RD_ACC;
                    t_val   = ACC_LD;
                end
            end
            PH_RD_ACC: if (t_done) begin
                phase_d = PH_RECOV;
                t_load  = 1'b1;
                t_val   = REC_LD;
                capture = 1'b1;
            end
            PH_WR_PULSE: if (t_done) begin
                phase_d = PH_WR_HOLD;
                t_load  = 1'b1;
                t_val   = HOLD_LD;
            end
            PH_WR_HOLD: if (t_done) begin
                phase_d = PH_RECOV;
                t_load  = 1'b1;
                t_val   = REC_LD;
            end
            PH_RECOV: if (t_done) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            is_wr_q <= 1'b0;
            pins_q  <= STROBE_QUIET;
        end else begin
            phase_q <= phase_d;
            pins_q  <= strobes_of(phase_d);
            if (accept) is_wr_q <= req_write;
        end
    end

    assign idle   = (phase_q == PH_IDLE);
    assign accept = idle && req_valid;
    assign pins   = pins_q;
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rvalid_q;
    assign rsp_data   = rdata_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 20,
    parameter int ACCESS_NS  = 55,
    parameter int WPULSE_NS  = 45,
    parameter int HOLD_NS    = 0,
    parameter int RECOVER_NS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int ACC_CYC  = ns_to_cyc(ACCESS_NS, CLK_NS, 1);
    localparam int WP_CYC   = ns_to_cyc(WPULSE_NS, CLK_NS, 1);
    localparam int HOLD_CYC = ns_to_cyc(HOLD_NS, CLK_NS, 1);
    localparam int REC_CYC  = ns_to_cyc(RECOVER_NS, CLK_NS, 1);
    localparam int MAX_CYC  = max4(ACC_CYC, WP_CYC, HOLD_CYC, REC_CYC);
    localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic    accept, capture, idle;
    strobe_t pins;

    sram_ctrl_seq #(
        .ACC_CYC  (ACC_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .REC_CYC  (REC_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .idle      (idle),
        .accept    (accept),
        .capture   (capture),
        .pins      (pins)
    );

    sram_ctrl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    assign req_ready    = idle;
    assign mem_cs_n     = pins.cs_n;
    assign mem_wr_n     = pins.wr_n;
    assign mem_rd_n     = pins.rd_n;
    assign mem_dq_drive = pins.dq_drive;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic              mem_dq_drive
);
    // R2: the address moves only with both strobes high on both sides of the move
    assert_addr_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> (mem_cs_n && mem_wr_n && $past(mem_cs_n) && $past(mem_wr_n)));

    // R3: ready is offered only with the bus quiet
    assert_ready_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_drive));

    // R4: output enable low implies a read, never a write
    assert_read_wr_high_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> (mem_wr_n && !mem_cs_n));

    // R5: during the write pulse chip enable is low, output enable high, data driven
    assert_write_shape_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> (!mem_cs_n && mem_rd_n && mem_dq_drive));

    // R6: drivers turn on only after output enable has been high a full cycle
    assert_drive_on_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_drive) |-> ($past(mem_rd_n) && mem_rd_n));

    // R6: drivers still on in the cycle write enable rises
    assert_drive_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_n) |-> mem_dq_drive);

    // R6: drivers turn off only after write enable has been high a cycle
    assert_drive_off_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_drive) |-> ($past(mem_wr_n) && mem_wr_n));

    // R8: read completion is a single-cycle pulse
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .mem_addr     (mem_addr),
    .mem_cs_n     (mem_cs_n),
    .mem_wr_n     (mem_wr_n),
    .mem_rd_n     (mem_rd_n),
    .mem_dq_drive (mem_dq_drive)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
    localparam int CLK_NS   = 20;
    localparam int ACC      = (55 + CLK_NS - 1) / CLK_NS;  // 3
    localparam int WP       = (45 + CLK_NS - 1) / CLK_NS;  // 3
    localparam int HOLD     = 1;
    localparam int REC      = 1;
    localparam int RD_RSP   = ACC + 2;               // negedge index of rsp pulse
    localparam int RD_DONE  = ACC + REC + 2;         // negedge index of ready again
    localparam int WR_DONE  = WP + HOLD + REC + 2;
    localparam int MODEL_ACC = ACC - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_data;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_drive;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sram_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n),
        .mem_rd_n(mem_rd_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
        .mem_dq_in(mem_dq_in)
    );

    // ---------------- behavioural RAM model with rule checks ----------------
    logic [7:0]  ram [int];
    logic [18:0] m_addr_q = '0;
    logic        m_cs_q = 1'b1, m_wr_q = 1'b1, m_ov_q = 1'b0;
    logic [7:0]  m_dq_q = '0, m_rd_q = '0;
    int          acc_cnt = 0;
    int          viol = 0;

    always @(posedge clk) begin
        logic ov;
        ov = !mem_cs_n && !mem_wr_n;
        if (!rst) begin
            if (mem_addr != m_addr_q && !(mem_cs_n && mem_wr_n && m_cs_q && m_wr_q)) viol++;
            if (ov && !mem_dq_drive) viol++;
            if (mem_dq_drive && !mem_rd_n && !mem_cs_n) viol++;
            if (m_ov_q && !ov) ram[int'(m_addr_q)] = m_dq_q;
        end
        if (!mem_cs_n && !mem_rd_n && mem_addr == m_addr_q) acc_cnt = acc_cnt + 1;
        else acc_cnt = 0;
        m_rd_q   <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
        m_addr_q <= mem_addr;
        m_cs_q   <= mem_cs_n;
        m_wr_q   <= mem_wr_n;
        m_ov_q   <= ov;
        m_dq_q   <= mem_dq_out;
    end

    assign mem_dq_in = (!mem_cs_n && !mem_rd_n && mem_wr_n && acc_cnt >= MODEL_ACC) ? m_rd_q : 8'hEE;

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_op(input logic wr, input logic [18:0] a, input logic [7:0] d, input logic [7:0] e);
        int c;
        int rsp_at;
        logic [7:0] rsp_val;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        c = 0;
        while (!req_ready && c < 50) begin @(negedge clk); c++; end
        @(negedge clk);
        // scramble request inputs while busy: must not matter (R3)
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        c = 1; rsp_at = 0; rsp_val = 8'h00;
        while (!req_ready && c < 50) begin
            if (c == 2) chk(mem_addr == a, "R2 address on pins", 32'(mem_addr), 32'(a));
            if (wr && c == 3) chk(!mem_wr_n && mem_dq_out == d, "R5 write data during pulse",
                                  {mem_wr_n, 23'd0, mem_dq_out}, {1'b0, 23'd0, d});
            if (rsp_valid) begin rsp_at = c; rsp_val = rsp_data; end
            @(negedge clk); c++;
        end
        if (wr) begin
            chk(rsp_at == 0, "R5 no response on write", 32'(rsp_at), 32'd0);
            chk(c == WR_DONE, "R7 write turnaround", 32'(c), 32'(WR_DONE));
        end else begin
            chk(rsp_at == RD_RSP, "R8 read response cycle", 32'(rsp_at), 32'(RD_RSP));
            chk(rsp_val == e, "R4 read data", 32'(rsp_val), 32'(e));
            chk(c == RD_DONE, "R7 read turnaround", 32'(c), 32'(RD_DONE));
        end
    endtask

    // {write, addr, data, expected}
    localparam int NV = 11;
    localparam logic [35:0] VEC [0:NV-1] = '{
        {1'b1, 19'h12345, 8'h5A, 8'h00},
        {1'b1, 19'h7FFFF, 8'hA5, 8'h00},
        {1'b1, 19'h00000, 8'h01, 8'h00},
        {1'b0, 19'h12345, 8'h00, 8'h5A},
        {1'b0, 19'h7FFFF, 8'h00, 8'hA5},
        {1'b0, 19'h00000, 8'h00, 8'h01},
        {1'b1, 19'h12345, 8'hC3, 8'h00},
        {1'b0, 19'h12345, 8'h00, 8'hC3},
        {1'b0, 19'h00001, 8'h00, 8'h00},
        {1'b1, 19'h00001, 8'hFF, 8'h00},
        {1'b0, 19'h00001, 8'h00, 8'hFF}
    };

    initial begin
        @(negedge clk);
        chk(mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_drive && req_ready && !rsp_valid,
            "R1 pins during reset",
            {26'd0, mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_drive, req_ready, rsp_valid}, 32'h3A);
        do_reset();
        chk(mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_drive && req_ready && !rsp_valid,
            "R1 pins after reset",
            {26'd0, mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_drive, req_ready, rsp_valid}, 32'h3A);

        // table walk: requests issued back to back
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][35], VEC[i][34:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R3: idle with request inputs toggling but valid low: pins stay quiet
        req_valid = 1'b0; req_addr = 19'h55555; req_write = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_wr_n && mem_addr == 19'h00001, "R3 no accept without valid",
            {mem_cs_n, mem_wr_n, 11'd0, mem_addr}, {2'b11, 11'd0, 19'h00001});

        // R1: reset in the middle of a write pulse
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00002; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!mem_wr_n && !mem_cs_n, "R5 pulse active before mid-op reset",
            {30'd0, mem_wr_n, mem_cs_n}, 32'd0);
        do_reset();
        chk(mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_drive && req_ready,
            "R1 pins after mid-op reset",
            {27'd0, mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_drive, req_ready}, 32'h1D);

        // operation still correct after the reset
        do_op(1'b0, 19'h7FFFF, 8'h00, 8'hA5);

        chk(viol == 0, "R2/R5/R6 RAM model rule violations", 32'(viol), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule